// File: doc/BRIEF.md
# DMA Completion Interrupt Controller with Shadow Regions

This block receives transfer-completion reports from a DMA channel controller and turns them into interrupt pulses. Each report carries a completion code, flags that say whether it is a final or an intermediate completion, and the per-transfer enables for those two kinds of interrupt. When a report qualifies, the block sets the pending bit whose index equals the completion code. The channel that produced the report does not select the bit.

A single global interrupt line watches the pending bits that are masked by the interrupt enable vector. Each shadow region has its own line. A region line also requires that region's access-enable bit at the same code index. Every line emits a one-cycle pulse when its set of enabled pending bits goes from empty to non-empty. Software reads the pending vector and clears the bits it has serviced through a clear port. It can raise an evaluate strobe to get a fresh pulse on every line that still has enabled bits pending.

Top module: `cic_irq_ctrl`

## Requirements
- R1: A valid report with the final flag and the final-interrupt enable both high sets pending bit `code` on the next clock edge.
- R2: A valid report sets no pending bit unless (final flag and final enable) or (intermediate flag and intermediate enable) holds. An intermediate flag with its enable high does set bit `code`.
- R3: The pending bit that is set is the one numbered by the 5-bit completion code. Code 0 sets bit 0 and code 31 sets bit 31.
- R4: The global line pulses only for pending bits whose interrupt enable bit is 1. A pending bit whose enable bit is 0 produces no global pulse.
- R5: Region line r pulses only when some pending bit has both its interrupt enable bit and bit `code` of region r's access mask set to 1.
- R6: A line pulses once, one cycle after its enabled pending set becomes non-empty. A later completion that arrives while enabled bits are still pending gives no new pulse.
- R7: After software clears all enabled pending bits with the clear port (1 in mask = clear), the next qualifying completion pulses the line again.
- R8: If a completion and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: An evaluate strobe makes each line pulse on the next cycle if that line has enabled pending bits. A line with none stays low.
- R10: While reset is held and after its release, the pending vector is zero and all interrupt lines are low.
- R11: Every interrupt pulse lasts exactly one clock cycle unless an evaluate strobe or a new rising condition extends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_valid | input | 1 | Completion report valid this cycle |
| cmpl_code | input | CODE_W (5) | Completion code; selects the pending bit |
| cmpl_final | input | 1 | Report is a final completion |
| cmpl_inter | input | 1 | Report is an intermediate completion |
| cmpl_final_en | input | 1 | Per-transfer final-interrupt enable |
| cmpl_inter_en | input | 1 | Per-transfer intermediate-interrupt enable |
| int_en | input | NUM_CODES (32) | Interrupt enable vector, one bit per code |
| rgn_mask | input | NUM_REGIONS x NUM_CODES | Access-enable mask per shadow region |
| clr_valid | input | 1 | Apply the clear mask this cycle |
| clr_mask | input | NUM_CODES | Pending bits to clear (1 = clear) |
| eval_strobe | input | 1 | Re-evaluate and re-pulse lines with enabled pending bits |
| pend | output | NUM_CODES | Pending vector |
| gbl_irq | output | 1 | Global interrupt pulse |
| rgn_irq | output | NUM_REGIONS (4) | Shadow-region interrupt pulses |

## Verification
The bench builds the block with its defaults: 32 codes, a 5-bit code field and 4 regions. These make the extreme codes 0 and 31 reachable, and that is where an index or width slip would show. Each of the four regions gets a distinct mask: all ones, a single middle bit, all zeros, and only the top bit. One completion therefore shows in a single pass which region lines must and must not pulse. The interrupt enable vector has one bit held low, so the global gating can be seen at the ports.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int DEF_CODES   = 32;
  localparam int DEF_REGIONS = 4;

  // A report counts when its kind matches the enable for that kind.
  function automatic logic cmpl_fires(input logic fin, input logic itr,
                                      input logic fin_en, input logic itr_en);
    return (fin && fin_en) || (itr && itr_en);
  endfunction
endpackage

// File: rtl/cic_pend_reg.sv
module cic_pend_reg #(
  parameter int NUM_CODES = 32,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_hit,
  input  logic [CODE_W-1:0]    set_code,
  input  logic                 clr_valid,
  input  logic [NUM_CODES-1:0] clr_mask,
  output logic [NUM_CODES-1:0] pend_q,
  output logic [NUM_CODES-1:0] set_vec,
  output logic [NUM_CODES-1:0] clr_vec
);
  function automatic logic [NUM_CODES-1:0] code_onehot(input logic [CODE_W-1:0] c);
    logic [NUM_CODES-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  always_comb begin
    set_vec = set_hit ? code_onehot(set_code) : '0;
    clr_vec = clr_valid ? clr_mask : '0;
  end

  // Set is applied after clear so a collision leaves the bit set.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/cic_irq_gen.sv
module cic_irq_gen #(
  parameter int NUM_CODES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CODES-1:0] pend,
  input  logic [NUM_CODES-1:0] gate,
  input  logic                 eval,
  output logic                 active,
  output logic                 irq
);
  logic active_q;

  assign active = |(pend & gate);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      irq      <= 1'b0;
    end else begin
      active_q <= active;
      irq      <= active && (!active_q || eval);
    end
  end
endmodule

// File: rtl/cic_irq_ctrl.sv
module cic_irq_ctrl
  import cic_pkg::*;
#(
  parameter int NUM_CODES   = DEF_CODES,
  parameter int NUM_REGIONS = DEF_REGIONS,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmpl_valid,
  input  logic [CODE_W-1:0]                     cmpl_code,
  input  logic                                  cmpl_final,
  input  logic                                  cmpl_inter,
  input  logic                                  cmpl_final_en,
  input  logic                                  cmpl_inter_en,
  input  logic [NUM_CODES-1:0]                  int_en,
  input  logic [NUM_REGIONS-1:0][NUM_CODES-1:0] rgn_mask,
  input  logic                                  clr_valid,
  input  logic [NUM_CODES-1:0]                  clr_mask,
  input  logic                                  eval_strobe,
  output logic [NUM_CODES-1:0]                  pend,
  output logic                                  gbl_irq,
  output logic [NUM_REGIONS-1:0]                rgn_irq
);
  // Named internal events, visible to the bound checker.
  logic                   cmpl_hit;
  logic [NUM_CODES-1:0]   set_vec;
  logic [NUM_CODES-1:0]   clr_vec;
  logic                   g_active;
  logic [NUM_REGIONS-1:0] r_active;

  assign cmpl_hit = cmpl_valid &&
                    cmpl_fires(cmpl_final, cmpl_inter, cmpl_final_en, cmpl_inter_en);

  cic_pend_reg #(.NUM_CODES(NUM_CODES)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_hit  (cmpl_hit),
    .set_code (cmpl_code),
    .clr_valid(clr_valid),
    .clr_mask (clr_mask),
    .pend_q   (pend),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec)
  );

  cic_irq_gen #(.NUM_CODES(NUM_CODES)) u_gbl (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .gate  (int_en),
    .eval  (eval_strobe),
    .active(g_active),
    .irq   (gbl_irq)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    logic [NUM_CODES-1:0] rgate;
    assign rgate = int_en & rgn_mask[r];
    cic_irq_gen #(.NUM_CODES(NUM_CODES)) u_rgn (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .gate  (rgate),
      .eval  (eval_strobe),
      .active(r_active[r]),
      .irq   (rgn_irq[r])
    );
  end
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int NUM_CODES   = 32,
  parameter int NUM_REGIONS = 4,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmpl_hit,
  input logic [CODE_W-1:0]      cmpl_code,
  input logic                   clr_valid,
  input logic                   eval_strobe,
  input logic [NUM_CODES-1:0]   pend,
  input logic                   g_active,
  input logic [NUM_REGIONS-1:0] r_active,
  input logic                   gbl_irq,
  input logic [NUM_REGIONS-1:0] rgn_irq
);
  AST_HIT_SETS_CODE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_hit |=> pend[$past(cmpl_code)]); // R8

  AST_QUIET_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmpl_hit && !clr_valid) |=> $stable(pend)); // R2

  AST_GBL_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    gbl_irq |-> $past(g_active)); // R4

  AST_NO_REPEAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (g_active && $past(g_active) && !eval_strobe) |=> !gbl_irq); // R6

  AST_EVAL_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && g_active) |=> gbl_irq); // R9

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_ra
    AST_RGN_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_irq[r] |-> $past(r_active[r])); // R5
  end
endmodule

bind cic_irq_ctrl cic_checker #(.NUM_CODES(NUM_CODES), .NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmpl_hit   (cmpl_hit),
  .cmpl_code  (cmpl_code),
  .clr_valid  (clr_valid),
  .eval_strobe(eval_strobe),
  .pend       (pend),
  .g_active   (g_active),
  .r_active   (r_active),
  .gbl_irq    (gbl_irq),
  .rgn_irq    (rgn_irq)
);

// File: tb/cic_irq_ctrl_test.sv
module cic_irq_ctrl_test;
  localparam int NC = 32;
  localparam int NR = 4;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmpl_valid = 1'b0;
  logic [CW-1:0] cmpl_code = '0;
  logic cmpl_final = 1'b0, cmpl_inter = 1'b0, cmpl_final_en = 1'b0, cmpl_inter_en = 1'b0;
  logic [NC-1:0] int_en = '0;
  logic [NR-1:0][NC-1:0] rgn_mask = '0;
  logic clr_valid = 1'b0;
  logic [NC-1:0] clr_mask = '0;
  logic eval_strobe = 1'b0;
  logic [NC-1:0] pend;
  logic gbl_irq;
  logic [NR-1:0] rgn_irq;

  int checks = 0;
  int errors = 0;
  int pulses [0:NR];  // index 0 global, 1..NR regions

  always #4 clk = ~clk;  // 8 ns period

  cic_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
    .cmpl_final(cmpl_final), .cmpl_inter(cmpl_inter), .cmpl_final_en(cmpl_final_en),
    .cmpl_inter_en(cmpl_inter_en), .int_en(int_en), .rgn_mask(rgn_mask),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .eval_strobe(eval_strobe),
    .pend(pend), .gbl_irq(gbl_irq), .rgn_irq(rgn_irq)
  );

  // Pulses are counted at falling edges; each high cycle spans exactly one.
  always @(negedge clk) begin
    if (gbl_irq) pulses[0]++;
    for (int r = 0; r < NR; r++) if (rgn_irq[r]) pulses[r+1]++;
  end

  // Vector: {code[4:0], final, inter, final_en, inter_en}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {5'd0,  4'b1010}, {5'd31, 4'b1010}, {5'd17, 4'b0101}, {5'd9,  4'b1001},
    {5'd22, 4'b0110}, {5'd4,  4'b0000}, {5'd30, 4'b1111}, {5'd1,  4'b0100}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic zero_pulses();
    for (int i = 0; i <= NR; i++) pulses[i] = 0;
  endtask

  task automatic complete(input logic [CW-1:0] c, input logic f, input logic i,
                          input logic fe, input logic ie);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_code = c; cmpl_final = f; cmpl_inter = i;
    cmpl_final_en = fe; cmpl_inter_en = ie;
    @(negedge clk);
    cmpl_valid = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_valid = 1'b1; clr_mask = '1;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 200000; k++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    zero_pulses();
    int_en = '1;
    int_en[10] = 1'b0;
    rgn_mask[0] = '1;
    rgn_mask[1] = 32'h0000_0080;
    rgn_mask[2] = '0;
    rgn_mask[3] = 32'h8000_0000;

    // R10: reset state, also with a completion offered during reset
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_code = 5'd3; cmpl_final = 1'b1; cmpl_final_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 pend in reset", 64'(pend), 64'h0);
    chk("R10 irqs in reset", 64'({gbl_irq, rgn_irq}), 64'h0);
    cmpl_valid = 1'b0;
    rst_n = 1'b1;
    settle();
    chk("R10 pend after reset", 64'(pend), 64'h0);
    chk("R10 no pulses after reset", 64'(pulses[0]), 64'd0);

    // Table walk: R1, R2, R3
    for (int v = 0; v < NV; v++) begin
      logic [CW-1:0] c;
      logic f, i, fe, ie;
      logic [NC-1:0] exp;
      {c, f, i, fe, ie} = VEC[v];
      clear_all();
      complete(c, f, i, fe, ie);
      exp = ((f && fe) || (i && ie)) ? (NC'(1) << c) : '0;
      chk("R1 R2 R3 table pend", 64'(pend), 64'(exp));
    end
    settle();

    // R6: rising pulse once; second completion while pending gives none
    clear_all(); settle(); zero_pulses();
    complete(5'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 no pulse before next edge", 64'(gbl_irq), 64'd0);
    @(negedge clk);
    chk("R6 pulse one cycle after set", 64'(gbl_irq), 64'd1);
    @(negedge clk);
    chk("R11 pulse ends", 64'(gbl_irq), 64'd0);
    complete(5'd4, 1'b1, 1'b0, 1'b1, 1'b0);
    settle();
    chk("R6 single pulse for two completions", 64'(pulses[0]), 64'd1);
    chk("R6 both bits pending", 64'(pend), 64'h18);

    // R7: clear then new completion pulses again
    clear_all();
    complete(5'd4, 1'b1, 1'b0, 1'b1, 1'b0);
    settle();
    chk("R7 pulse after clear", 64'(pulses[0]), 64'd2);

    // R8: same-cycle set and clear on the same bit
    clear_all(); settle();
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_code = 5'd5; cmpl_final = 1'b1; cmpl_final_en = 1'b1;
    cmpl_inter = 1'b0; cmpl_inter_en = 1'b0;
    clr_valid = 1'b1; clr_mask = 32'h0000_0020;
    @(negedge clk);
    cmpl_valid = 1'b0; clr_valid = 1'b0; clr_mask = '0;
    chk("R8 set wins over clear", 64'(pend[5]), 64'd1);

    // R9: evaluate strobe re-pulses while pending, not when empty
    settle(); zero_pulses();
    @(negedge clk); eval_strobe = 1'b1;
    @(negedge clk); eval_strobe = 1'b0;
    chk("R9 eval pulse", 64'(gbl_irq), 64'd1);
    settle();
    chk("R9 eval pulse count", 64'(pulses[0]), 64'd1);
    clear_all(); settle(); zero_pulses();
    @(negedge clk); eval_strobe = 1'b1;
    @(negedge clk); eval_strobe = 1'b0;
    settle();
    chk("R9 no pulse when empty", 64'(pulses[0]), 64'd0);

    // R4: code with enable bit 0 pends but does not pulse
    complete(5'd10, 1'b1, 1'b0, 1'b1, 1'b0);
    settle();
    chk("R4 disabled code pends", 64'(pend[10]), 64'd1);
    chk("R4 no global pulse", 64'(pulses[0]), 64'd0);
    chk("R4 no region pulse", 64'(pulses[1]), 64'd0);

    // R5: region masks, code 7 then code 31
    clear_all(); settle(); zero_pulses();
    complete(5'd7, 1'b0, 1'b1, 1'b0, 1'b1);
    settle();
    chk("R5 code7 global", 64'(pulses[0]), 64'd1);
    chk("R5 code7 region0", 64'(pulses[1]), 64'd1);
    chk("R5 code7 region1", 64'(pulses[2]), 64'd1);
    chk("R5 code7 region2", 64'(pulses[3]), 64'd0);
    chk("R5 code7 region3", 64'(pulses[4]), 64'd0);
    clear_all(); settle(); zero_pulses();
    complete(5'd31, 1'b1, 1'b0, 1'b1, 1'b0);
    settle();
    chk("R5 code31 region1", 64'(pulses[2]), 64'd0);
    chk("R5 code31 region3", 64'(pulses[4]), 64'd1);
    chk("R5 code31 region2", 64'(pulses[3]), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule